// File: doc/BRIEF.md
# Cartridge DMA Controller

This block moves data between a cartridge address space and main RAM on behalf of a CPU. Software programs a RAM address and a cartridge address through a small register window, then writes a length register. That length write launches the copy at once. There are two length registers, one for each direction. The copy proceeds one 16-bit halfword per beat through two single-outstanding request/valid ports, one for the cartridge and one for RAM.

The block can also perform a single 32-bit access to cartridge space for the CPU. It does this as two halfword beats. A status register reports whether such an access or a copy is in flight. A completion interrupt stays pending until software clears it.

The RAM address is a physical offset, with no cached-segment base added. Software polls the two busy bits and starts new work only after both read zero.

Top module: `cart_dma`

## Requirements
- R1: Register window, indexed by `cpu_addr[4:2]`:
  - index 0 holds the RAM address (RAM_AW bits);
  - index 1 holds the cartridge address (CART_AW bits);
  - index 2 holds the RAM-to-cartridge length;
  - index 3 holds the cartridge-to-RAM length;
  - index 4 is status.
  - Bit 0 of both address registers is forced to zero on write, and reads return the stored value.
- R2: A write to index 3 starts a copy from cartridge to RAM. A write to index 2 starts a copy from RAM to cartridge. Both use the currently held addresses.
- R3: A programmed length L moves floor(L/2)+1 halfwords, so L is the byte count minus one. Beat k uses address base+2k on both sides, and each halfword reaches its destination unchanged.
- R4: Status bit 1 reads 1 from the cycle after the starting length write until the last destination beat is acknowledged. Status bit 0 reads 1 while a single 32-bit access is in flight.
- R5: While status bits [1:0] are not both zero, writes to indices 0 to 3 are ignored. A new single-access request (`io_req`) is also refused: it produces no cartridge beat and no `io_done`.
- R6: `irq` and status bit 3 go to 1 when a copy completes. They stay at 1 until a status write with bit 1 set. Writes with bit 1 clear leave them unchanged.
- R7: A single access uses the word address with bits [1:0] cleared. It issues the high halfword at that address first, then the low halfword at address+2. It ends with a one-cycle `io_done` pulse. For a read, `io_rdata` then holds {high, low}.
- R8: Each port has at most one request outstanding. A request is a one-cycle pulse, and the next request on that port waits for the `valid` of the previous one.
- R9: After reset, status reads 0, `irq` is 0, and no request is driven on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_sel | input | 1 | Register access strobe |
| cpu_we | input | 1 | Register write when 1, read when 0 |
| cpu_addr | input | 5 | Register byte offset |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data (combinational) |
| io_req | input | 1 | Single 32-bit cartridge access request pulse |
| io_we | input | 1 | Single access is a write |
| io_addr | input | CART_AW | Single access byte address |
| io_wdata | input | 32 | Single access write data |
| io_rdata | output | 32 | Single access read data, valid with io_done |
| io_done | output | 1 | Single access completion pulse |
| irq | output | 1 | Copy-complete interrupt, level |
| cart_req | output | 1 | Cartridge beat request pulse |
| cart_we | output | 1 | Cartridge beat is a write |
| cart_addr | output | CART_AW | Cartridge beat byte address |
| cart_wdata | output | 16 | Cartridge write halfword |
| cart_rdata | input | 16 | Cartridge read halfword |
| cart_valid | input | 1 | Cartridge beat acknowledge / read data valid |
| ram_req | output | 1 | RAM beat request pulse |
| ram_we | output | 1 | RAM beat is a write |
| ram_addr | output | RAM_AW | RAM beat byte address |
| ram_wdata | output | 16 | RAM write halfword |
| ram_rdata | input | 16 | RAM read halfword |
| ram_valid | input | 1 | RAM beat acknowledge / read data valid |

## Verification
The copy engine is exercised in both directions with these patterns:
- Directed lengths 0, 1, 2 and 7 separate the rounding of odd and even lengths from an off-by-one in the beat count.
- Random lengths, odd base addresses and responder latencies of one to three cycles show whether the address stepping and alignment hold under uneven acknowledge timing.
- A long copy disturbed by register writes, a second length write and a single-access request shows that work arriving while busy leaves no trace.

Separate single-access reads and writes at a misaligned address check halfword order and word alignment.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

  // register window word indices (cpu_addr[4:2])
  localparam logic [2:0] REG_RAM_ADR  = 3'd0;
  localparam logic [2:0] REG_CART_ADR = 3'd1;
  localparam logic [2:0] REG_LEN_TOC  = 3'd2;  // RAM -> cartridge
  localparam logic [2:0] REG_LEN_TOR  = 3'd3;  // cartridge -> RAM
  localparam logic [2:0] REG_STATUS   = 3'd4;

  // status bit positions
  localparam int ST_IO_BIT  = 0;
  localparam int ST_DMA_BIT = 1;
  localparam int ST_IRQ_BIT = 3;

  typedef enum logic [2:0] {
    XS_IDLE, XS_SRC_REQ, XS_SRC_WAIT, XS_DST_REQ, XS_DST_WAIT
  } xfer_st_e;

  typedef enum logic [2:0] {
    PS_IDLE, PS_HI_REQ, PS_HI_WAIT, PS_LO_REQ, PS_LO_WAIT
  } pio_st_e;

endpackage

// File: rtl/cdma_regs.sv
module cdma_regs
  import cdma_pkg::*;
#(
  parameter int RAM_AW  = 24,
  parameter int CART_AW = 32,
  parameter int LEN_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_sel,
  input  logic               cpu_we,
  input  logic [4:0]         cpu_addr,
  input  logic [31:0]        cpu_wdata,
  output logic [31:0]        cpu_rdata,
  input  logic               io_busy,
  input  logic               dma_busy,
  input  logic               dma_done,
  output logic [RAM_AW-1:0]  ram_base,
  output logic [CART_AW-1:0] cart_base,
  output logic [LEN_W-1:0]   len,
  output logic               start,
  output logic               to_ram,
  output logic               irq
);

  logic [2:0]         idx;
  logic               wr, locked, clr;
  logic [RAM_AW-1:0]  ram_q, ram_d;
  logic [CART_AW-1:0] cart_q, cart_d;
  logic [LEN_W-1:0]   ltoc_q, ltor_q;
  logic               irq_q, irq_d;
  logic               ram_en, cart_en, ltoc_en, ltor_en;

  always_comb begin
    idx     = cpu_addr[4:2];
    wr      = cpu_sel & cpu_we;
    locked  = io_busy | dma_busy;
    ram_en  = wr & ~locked & (idx == REG_RAM_ADR);
    cart_en = wr & ~locked & (idx == REG_CART_ADR);
    ltoc_en = wr & ~locked & (idx == REG_LEN_TOC);
    ltor_en = wr & ~locked & (idx == REG_LEN_TOR);
    ram_d   = {cpu_wdata[RAM_AW-1:1], 1'b0};
    cart_d  = {cpu_wdata[CART_AW-1:1], 1'b0};
    clr     = wr & (idx == REG_STATUS) & cpu_wdata[ST_DMA_BIT];
    irq_d   = dma_done | (irq_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_q  <= '0;
      cart_q <= '0;
      ltoc_q <= '0;
      ltor_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ram_en)  ram_q  <= ram_d;
      if (cart_en) cart_q <= cart_d;
      if (ltoc_en) ltoc_q <= cpu_wdata[LEN_W-1:0];
      if (ltor_en) ltor_q <= cpu_wdata[LEN_W-1:0];
      irq_q <= irq_d;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    unique case (idx)
      REG_RAM_ADR:  cpu_rdata[RAM_AW-1:0]  = ram_q;
      REG_CART_ADR: cpu_rdata[CART_AW-1:0] = cart_q;
      REG_LEN_TOC:  cpu_rdata[LEN_W-1:0]   = ltoc_q;
      REG_LEN_TOR:  cpu_rdata[LEN_W-1:0]   = ltor_q;
      REG_STATUS: begin
        cpu_rdata[ST_IO_BIT]  = io_busy;
        cpu_rdata[ST_DMA_BIT] = dma_busy;
        cpu_rdata[ST_IRQ_BIT] = irq_q;
      end
      default: cpu_rdata = '0;
    endcase
  end

  assign ram_base  = ram_q;
  assign cart_base = cart_q;
  assign len       = cpu_wdata[LEN_W-1:0];
  assign start     = ltoc_en | ltor_en;
  assign to_ram    = ltor_en;
  assign irq       = irq_q;

endmodule

// File: rtl/cdma_xfer.sv
module cdma_xfer
  import cdma_pkg::*;
#(
  parameter int RAM_AW  = 24,
  parameter int CART_AW = 32,
  parameter int LEN_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               to_ram,
  input  logic [LEN_W-1:0]   len,
  input  logic [RAM_AW-1:0]  ram_base,
  input  logic [CART_AW-1:0] cart_base,
  output logic               busy,
  output logic               done,
  output logic               cart_req,
  output logic               cart_we,
  output logic [CART_AW-1:0] cart_addr,
  output logic [15:0]        cart_wdata,
  input  logic [15:0]        cart_rdata,
  input  logic               cart_valid,
  output logic               ram_req,
  output logic               ram_we,
  output logic [RAM_AW-1:0]  ram_addr,
  output logic [15:0]        ram_wdata,
  input  logic [15:0]        ram_rdata,
  input  logic               ram_valid
);

  xfer_st_e           st_q, st_d;
  logic               dir_q;          // 1: cartridge -> RAM
  logic [LEN_W-1:0]   left_q, left_d;
  logic [RAM_AW-1:0]  ra_q, ra_d;
  logic [CART_AW-1:0] ca_q, ca_d;
  logic [15:0]        buf_q;
  logic               load, cap, step, last;
  logic               src_valid, dst_valid;
  logic [15:0]        src_data;

  always_comb begin
    src_valid = dir_q ? cart_valid : ram_valid;
    dst_valid = dir_q ? ram_valid  : cart_valid;
    src_data  = dir_q ? cart_rdata : ram_rdata;
    last      = (left_q == LEN_W'(1));
    load      = (st_q == XS_IDLE) & start;
    cap       = (st_q == XS_SRC_WAIT) & src_valid;
    step      = (st_q == XS_DST_WAIT) & dst_valid;
    ra_d      = load ? ram_base  : ra_q + RAM_AW'(2);
    ca_d      = load ? cart_base : ca_q + CART_AW'(2);
    left_d    = load ? ({1'b0, len[LEN_W-1:1]} + LEN_W'(1)) : left_q - LEN_W'(1);
    st_d      = st_q;
    unique case (st_q)
      XS_IDLE:     if (start) st_d = XS_SRC_REQ;
      XS_SRC_REQ:  st_d = XS_SRC_WAIT;
      XS_SRC_WAIT: if (src_valid) st_d = XS_DST_REQ;
      XS_DST_REQ:  st_d = XS_DST_WAIT;
      XS_DST_WAIT: if (dst_valid) st_d = last ? XS_IDLE : XS_SRC_REQ;
      default:     st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XS_IDLE;
      dir_q  <= 1'b0;
      left_q <= '0;
      ra_q   <= '0;
      ca_q   <= '0;
      buf_q  <= '0;
    end else begin
      st_q <= st_d;
      if (load) dir_q <= to_ram;
      if (load | step) begin
        left_q <= left_d;
        ra_q   <= ra_d;
        ca_q   <= ca_d;
      end
      if (cap) buf_q <= src_data;
    end
  end

  assign busy       = (st_q != XS_IDLE);
  assign done       = step & last;
  assign cart_req   = ((st_q == XS_SRC_REQ) & dir_q) | ((st_q == XS_DST_REQ) & ~dir_q);
  assign cart_we    = (st_q == XS_DST_REQ) & ~dir_q;
  assign ram_req    = ((st_q == XS_SRC_REQ) & ~dir_q) | ((st_q == XS_DST_REQ) & dir_q);
  assign ram_we     = (st_q == XS_DST_REQ) & dir_q;
  assign cart_addr  = ca_q;
  assign ram_addr   = ra_q;
  assign cart_wdata = buf_q;
  assign ram_wdata  = buf_q;

endmodule

// File: rtl/cdma_pio.sv
module cdma_pio
  import cdma_pkg::*;
#(
  parameter int CART_AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_req,
  input  logic               io_we,
  input  logic [CART_AW-1:0] io_addr,
  input  logic [31:0]        io_wdata,
  input  logic               accept,
  output logic               busy,
  output logic               done,
  output logic [31:0]        rdata,
  output logic               cart_req,
  output logic               cart_we,
  output logic [CART_AW-1:0] cart_addr,
  output logic [15:0]        cart_wdata,
  input  logic [15:0]        cart_rdata,
  input  logic               cart_valid
);

  pio_st_e            st_q, st_d;
  logic               we_q;
  logic [CART_AW-1:0] a_q;
  logic [31:0]        wd_q;
  logic [15:0]        hi_q, lo_q;
  logic               done_q;
  logic               load, hi_cap, lo_cap, in_lo;

  always_comb begin
    load   = (st_q == PS_IDLE) & io_req & accept;
    hi_cap = (st_q == PS_HI_WAIT) & cart_valid;
    lo_cap = (st_q == PS_LO_WAIT) & cart_valid;
    in_lo  = (st_q == PS_LO_REQ) | (st_q == PS_LO_WAIT);
    st_d   = st_q;
    unique case (st_q)
      PS_IDLE:    if (load) st_d = PS_HI_REQ;
      PS_HI_REQ:  st_d = PS_HI_WAIT;
      PS_HI_WAIT: if (cart_valid) st_d = PS_LO_REQ;
      PS_LO_REQ:  st_d = PS_LO_WAIT;
      PS_LO_WAIT: if (cart_valid) st_d = PS_IDLE;
      default:    st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      we_q   <= 1'b0;
      a_q    <= '0;
      wd_q   <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= lo_cap;
      if (load) begin
        we_q <= io_we;
        a_q  <= {io_addr[CART_AW-1:2], 2'b00};
        wd_q <= io_wdata;
      end
      if (hi_cap) hi_q <= cart_rdata;
      if (lo_cap) lo_q <= cart_rdata;
    end
  end

  assign busy       = (st_q != PS_IDLE);
  assign done       = done_q;
  assign rdata      = {hi_q, lo_q};
  assign cart_req   = (st_q == PS_HI_REQ) | (st_q == PS_LO_REQ);
  assign cart_we    = cart_req & we_q;
  assign cart_addr  = in_lo ? {a_q[CART_AW-1:2], 2'b10} : a_q;
  assign cart_wdata = in_lo ? wd_q[15:0] : wd_q[31:16];

endmodule

// File: rtl/cart_dma.sv
module cart_dma
  import cdma_pkg::*;
#(
  parameter int RAM_AW  = 24,
  parameter int CART_AW = 32,
  parameter int LEN_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_sel,
  input  logic               cpu_we,
  input  logic [4:0]         cpu_addr,
  input  logic [31:0]        cpu_wdata,
  output logic [31:0]        cpu_rdata,
  input  logic               io_req,
  input  logic               io_we,
  input  logic [CART_AW-1:0] io_addr,
  input  logic [31:0]        io_wdata,
  output logic [31:0]        io_rdata,
  output logic               io_done,
  output logic               irq,
  output logic               cart_req,
  output logic               cart_we,
  output logic [CART_AW-1:0] cart_addr,
  output logic [15:0]        cart_wdata,
  input  logic [15:0]        cart_rdata,
  input  logic               cart_valid,
  output logic               ram_req,
  output logic               ram_we,
  output logic [RAM_AW-1:0]  ram_addr,
  output logic [15:0]        ram_wdata,
  input  logic [15:0]        ram_rdata,
  input  logic               ram_valid
);

  logic               rst_meta_n, rst_sync_n;
  logic [RAM_AW-1:0]  reg_ram_base;
  logic [CART_AW-1:0] reg_cart_base;
  logic [LEN_W-1:0]   reg_len;
  logic               reg_start, reg_to_ram;
  logic               x_busy, x_done, p_busy;
  logic               x_cart_req, x_cart_we, p_cart_req, p_cart_we;
  logic [CART_AW-1:0] x_cart_addr, p_cart_addr;
  logic [15:0]        x_cart_wdata, p_cart_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  cdma_regs #(.RAM_AW(RAM_AW), .CART_AW(CART_AW), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .io_busy(p_busy), .dma_busy(x_busy), .dma_done(x_done),
    .ram_base(reg_ram_base), .cart_base(reg_cart_base), .len(reg_len),
    .start(reg_start), .to_ram(reg_to_ram), .irq(irq)
  );

  cdma_xfer #(.RAM_AW(RAM_AW), .CART_AW(CART_AW), .LEN_W(LEN_W)) u_xfer (
    .clk(clk), .rst_n(rst_sync_n),
    .start(reg_start), .to_ram(reg_to_ram), .len(reg_len),
    .ram_base(reg_ram_base), .cart_base(reg_cart_base),
    .busy(x_busy), .done(x_done),
    .cart_req(x_cart_req), .cart_we(x_cart_we), .cart_addr(x_cart_addr),
    .cart_wdata(x_cart_wdata), .cart_rdata(cart_rdata), .cart_valid(cart_valid),
    .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .ram_valid(ram_valid)
  );

  cdma_pio #(.CART_AW(CART_AW)) u_pio (
    .clk(clk), .rst_n(rst_sync_n),
    .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
    .accept(~x_busy & ~reg_start),
    .busy(p_busy), .done(io_done), .rdata(io_rdata),
    .cart_req(p_cart_req), .cart_we(p_cart_we), .cart_addr(p_cart_addr),
    .cart_wdata(p_cart_wdata), .cart_rdata(cart_rdata), .cart_valid(cart_valid)
  );

  // the two cartridge masters are never active together
  assign cart_req   = x_cart_req | p_cart_req;
  assign cart_we    = x_cart_we | p_cart_we;
  assign cart_addr  = p_busy ? p_cart_addr  : x_cart_addr;
  assign cart_wdata = p_busy ? p_cart_wdata : x_cart_wdata;

endmodule

// File: rtl/cdma_chk.sv
module cdma_chk #(
  parameter int RAM_AW = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_sel,
  input logic              cpu_we,
  input logic [4:0]        cpu_addr,
  input logic [31:0]       cpu_wdata,
  input logic [RAM_AW-1:0] ram_base,
  input logic              dma_busy,
  input logic              io_busy,
  input logic              irq,
  input logic              io_done,
  input logic              cart_req,
  input logic              cart_valid,
  input logic              ram_req,
  input logic              ram_valid
);

  logic cart_out, ram_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cart_out <= 1'b0;
      ram_out  <= 1'b0;
    end else begin
      if (cart_req) cart_out <= 1'b1;
      else if (cart_valid) cart_out <= 1'b0;
      if (ram_req) ram_out <= 1'b1;
      else if (ram_valid) ram_out <= 1'b0;
    end
  end

  // R8
  cart_single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cart_req |-> !cart_out);

  // R8
  ram_single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req |-> !ram_out);

  // R5
  busy_addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dma_busy || io_busy) && cpu_sel && cpu_we && cpu_addr[4:2] == 3'd0)
    |=> $stable(ram_base));

  // R5
  io_dma_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_busy && io_busy));

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(cpu_sel && cpu_we && cpu_addr[4:2] == 3'd4 && cpu_wdata[1])) |=> irq);

  // R4
  irq_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !dma_busy);

  // R7
  io_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_done |-> !io_busy);

endmodule

bind cart_dma cdma_chk #(.RAM_AW(RAM_AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .ram_base(reg_ram_base), .dma_busy(x_busy), .io_busy(p_busy),
  .irq(irq), .io_done(io_done),
  .cart_req(cart_req), .cart_valid(cart_valid),
  .ram_req(ram_req), .ram_valid(ram_valid)
);

// File: tb/cart_dma_tb.sv
module cart_dma_tb;

  localparam int RAM_AW  = 24;
  localparam int CART_AW = 32;
  localparam int LEN_W   = 24;

  logic clk, rst_n;
  logic cpu_sel, cpu_we;
  logic [4:0]  cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic io_req, io_we;
  logic [CART_AW-1:0] io_addr;
  logic [31:0] io_wdata, io_rdata;
  logic io_done, irq;
  logic cart_req, cart_we, cart_valid;
  logic [CART_AW-1:0] cart_addr;
  logic [15:0] cart_wdata, cart_rdata;
  logic ram_req, ram_we, ram_valid;
  logic [RAM_AW-1:0] ram_addr;
  logic [15:0] ram_wdata, ram_rdata;

  cart_dma #(.RAM_AW(RAM_AW), .CART_AW(CART_AW), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_done(io_done), .irq(irq),
    .cart_req(cart_req), .cart_we(cart_we), .cart_addr(cart_addr),
    .cart_wdata(cart_wdata), .cart_rdata(cart_rdata), .cart_valid(cart_valid),
    .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .ram_valid(ram_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] cmem [256];
  logic [15:0] rmem [256];
  logic [15:0] cref [256];
  logic [15:0] rref [256];

  int n_chk, n_fail;
  int cw_cnt, rw_cnt, io_cnt, c_viol, r_viol;
  bit models_on;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // cartridge responder
  initial begin
    int pend;
    logic [15:0] hold;
    pend = 0;
    hold = '0;
    cart_valid = 1'b0;
    cart_rdata = '0;
    forever begin
      @(negedge clk);
      cart_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          cart_valid = 1'b1;
          cart_rdata = hold;
        end
      end
      if (models_on && cart_req) begin
        if (pend != 0) c_viol++;
        if (cart_we) begin
          cmem[cart_addr[8:1]] = cart_wdata;
          cw_cnt++;
        end else begin
          hold = cmem[cart_addr[8:1]];
        end
        pend = 1 + int'($urandom % 3);
      end
    end
  end

  // RAM responder
  initial begin
    int pend;
    logic [15:0] hold;
    pend = 0;
    hold = '0;
    ram_valid = 1'b0;
    ram_rdata = '0;
    forever begin
      @(negedge clk);
      ram_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          ram_valid = 1'b1;
          ram_rdata = hold;
        end
      end
      if (models_on && ram_req) begin
        if (pend != 0) r_viol++;
        if (ram_we) begin
          rmem[ram_addr[8:1]] = ram_wdata;
          rw_cnt++;
        end else begin
          hold = rmem[ram_addr[8:1]];
        end
        pend = 1 + int'($urandom % 3);
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (io_done) io_cnt++;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    finish_run();
  end

  task automatic cpu_write(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = {idx, 2'b00}; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = {idx, 2'b00};
    #1 d = cpu_rdata;
    cpu_sel = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      cpu_read(3'd4, s);
      if (s[1:0] == 2'b00) break;
    end
  endtask

  function automatic bit arrays_match();
    for (int i = 0; i < 256; i++)
      if (cmem[i] !== cref[i] || rmem[i] !== rref[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int beats_of(input logic [LEN_W-1:0] l);
    return int'(l >> 1) + 1;
  endfunction

  task automatic ref_copy(input bit to_ram, input logic [31:0] ra,
                          input logic [31:0] ca, input int nb);
    for (int k = 0; k < nb; k++) begin
      logic [7:0] ri, ci;
      ri = ra[8:1] + 8'(k);
      ci = ca[8:1] + 8'(k);
      if (to_ram) rref[ri] = cref[ci];
      else        cref[ci] = rref[ri];
    end
  endtask

  task automatic run_dma(input bit to_ram, input logic [31:0] ra,
                         input logic [31:0] ca, input logic [LEN_W-1:0] l,
                         input bit clear_irq);
    logic [31:0] s;
    int c0, r0, nb;
    nb = beats_of(l);
    cpu_write(3'd0, ra);
    cpu_write(3'd1, ca);
    c0 = cw_cnt; r0 = rw_cnt;
    cpu_write(to_ram ? 3'd3 : 3'd2, 32'(l));
    cpu_read(3'd4, s);
    chk(s[1] == 1'b1, "R4 dma busy after start", s, 32'h2);
    wait_idle();
    ref_copy(to_ram, ra, ca, nb);
    chk(arrays_match(), "R2 R3 copied data", 32'(l), 32'(nb));
    if (to_ram) chk(rw_cnt - r0 == nb, "R3 beat count", rw_cnt - r0, nb);
    else        chk(cw_cnt - c0 == nb, "R3 beat count", cw_cnt - c0, nb);
    chk(irq == 1'b1, "R6 irq on completion", {31'd0, irq}, 32'd1);
    if (clear_irq) begin
      cpu_write(3'd4, 32'h2);
      chk(irq == 1'b0, "R6 irq cleared", {31'd0, irq}, 32'd0);
    end
  endtask

  task automatic io_access(input bit we, input logic [31:0] a,
                           input logic [31:0] wd, output logic [31:0] rd);
    logic [31:0] s;
    bit got;
    got = 1'b0;
    rd = '0;
    @(negedge clk);
    io_req = 1'b1; io_we = we; io_addr = a; io_wdata = wd;
    @(negedge clk);
    io_req = 1'b0;
    #1 s = cpu_rdata;
    cpu_read(3'd4, s);
    chk(s[0] == 1'b1, "R4 io busy bit", s, 32'h1);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (io_done) begin
        rd = io_rdata;
        got = 1'b1;
        break;
      end
    end
    chk(got, "R7 io_done pulse", {31'd0, got}, 32'd1);
  endtask

  initial begin
    logic [31:0] v, rd;
    int io0, cw0;
    void'($urandom(32'h5eed));
    n_chk = 0; n_fail = 0; cw_cnt = 0; rw_cnt = 0; io_cnt = 0;
    c_viol = 0; r_viol = 0; models_on = 1'b0;
    cpu_sel = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    io_req = 0; io_we = 0; io_addr = '0; io_wdata = '0;
    for (int i = 0; i < 256; i++) begin
      cmem[i] = 16'($urandom); rmem[i] = 16'($urandom);
      cref[i] = cmem[i];       rref[i] = rmem[i];
    end
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    models_on = 1'b1;

    // R9 reset state
    cpu_read(3'd4, v);
    chk(v == 32'd0, "R9 status after reset", v, 32'd0);
    chk(irq == 1'b0, "R9 irq after reset", {31'd0, irq}, 32'd0);
    chk(cart_req == 1'b0, "R9 cart_req idle", {31'd0, cart_req}, 32'd0);
    chk(ram_req == 1'b0, "R9 ram_req idle", {31'd0, ram_req}, 32'd0);

    // R1 register readback and alignment
    cpu_write(3'd0, 32'h0012_3457);
    cpu_read(3'd0, v);
    chk(v == 32'h0012_3456, "R1 ram address readback", v, 32'h0012_3456);
    cpu_write(3'd1, 32'h10AB_CDE1);
    cpu_read(3'd1, v);
    chk(v == 32'h10AB_CDE0, "R1 cart address readback", v, 32'h10AB_CDE0);
    cpu_write(3'd3, 32'h0);  // starts a one-beat copy
    wait_idle();
    ref_copy(1'b1, 32'h0012_3456, 32'h10AB_CDE0, 1);
    cpu_write(3'd4, 32'h2);
    cpu_read(3'd3, v);
    chk(v == 32'h0, "R1 length readback", v, 32'h0);

    // directed lengths, both directions
    run_dma(1'b1, 32'h40, 32'h100, 24'd0, 1'b1);
    run_dma(1'b1, 32'h41, 32'h123, 24'd1, 1'b1);
    run_dma(1'b1, 32'h80, 32'h200, 24'd2, 1'b1);
    run_dma(1'b1, 32'h90, 32'h300, 24'd7, 1'b1);
    run_dma(1'b0, 32'h10, 32'h20,  24'd0, 1'b1);
    run_dma(1'b0, 32'h13, 32'h61,  24'd3, 1'b1);
    run_dma(1'b0, 32'hA0, 32'h1C0, 24'd7, 1'b1);

    // random copies
    for (int t = 0; t < 24; t++) begin
      run_dma(1'($urandom), 32'($urandom) & 32'h00FF_FFFF, 32'($urandom),
              24'($urandom % 64), 1'b1);
    end

    // R6 interrupt holds until a clearing write
    run_dma(1'b1, 32'h20, 32'h40, 24'd5, 1'b0);
    repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R6 irq held", {31'd0, irq}, 32'd1);
    cpu_write(3'd4, 32'h1);
    chk(irq == 1'b1, "R6 irq kept by write without bit1", {31'd0, irq}, 32'd1);
    cpu_read(3'd4, v);
    chk(v[3] == 1'b1, "R6 status irq bit", v, 32'h8);
    cpu_write(3'd4, 32'h2);
    chk(irq == 1'b0, "R6 irq cleared by bit1", {31'd0, irq}, 32'd0);

    // R5 writes and single access ignored while busy
    cpu_write(3'd0, 32'h100);
    cpu_write(3'd1, 32'h0);
    cpu_write(3'd3, 32'd63);
    io0 = io_cnt;
    cw0 = cw_cnt;
    cpu_write(3'd0, 32'h1F0);
    cpu_write(3'd1, 32'h80);
    cpu_write(3'd2, 32'd5);
    @(negedge clk);
    io_req = 1'b1; io_we = 1'b1; io_addr = 32'h80; io_wdata = 32'h1234_5678;
    @(negedge clk);
    io_req = 1'b0;
    wait_idle();
    ref_copy(1'b1, 32'h100, 32'h0, 32);
    repeat (10) @(negedge clk);
    chk(arrays_match(), "R5 only the first copy ran", 32'd0, 32'd0);
    chk(io_cnt == io0, "R5 io refused while busy", io_cnt - io0, 32'd0);
    chk(cw_cnt == cw0, "R5 no cartridge writes", cw_cnt - cw0, 32'd0);
    cpu_read(3'd0, v);
    chk(v == 32'h100, "R5 ram address unchanged", v, 32'h100);
    cpu_read(3'd1, v);
    chk(v == 32'h0, "R5 cart address unchanged", v, 32'h0);
    cpu_write(3'd4, 32'h2);

    // R7 single accesses, misaligned address
    io_access(1'b0, 32'h22, 32'h0, rd);
    chk(rd == {cref[8'h10], cref[8'h11]}, "R7 io read order", rd,
        {cref[8'h10], cref[8'h11]});
    io_access(1'b1, 32'h43, 32'hDEAD_BEEF, rd);
    cref[8'h20] = 16'hDEAD;
    cref[8'h21] = 16'hBEEF;
    chk(arrays_match(), "R7 io write halves", {cmem[8'h20], cmem[8'h21]},
        32'hDEAD_BEEF);
    chk(irq == 1'b0, "R7 io leaves irq", {31'd0, irq}, 32'd0);

    // R8 single outstanding request per port
    chk(c_viol == 0 && r_viol == 0, "R8 one outstanding request",
        32'(c_viol + r_viol), 32'd0);

    finish_run();
  end

endmodule